// File: doc/BRIEF.md
# Two-wire converter-side serial interface

This block is the converter-side controller of a two-wire link made of a clock line driven by a host (SCLK) and a data line driven back by the converter (SDAT). While it sleeps, SDAT sits high. A falling SCLK edge wakes it, latches the channel address and fires a one-cycle start strobe. A timed window then opens. Every further falling edge inside that window drops the resolution by one bit, down to a floor, and is acknowledged by a high level on SDAT.

When the window closes, the block times a conversion. That time halves for each bit of resolution removed. The block then raises SDAT to show the result is ready and returns to sleep. Later falling edges shift the result out one bit per edge, most significant first. The result is two's complement, truncated to the chosen resolution, and the sign-only code is never emitted. Once the last bit is out, the next falling edge starts a fresh conversion.

SCLK is resynchronised and filtered against short pulses before any edge is used. The result word comes from an external converter model.

Top module: `sdat_link`

## Requirements
- R1: After reset SDAT is high and start_o is low. A filtered falling SCLK edge in sleep pulses start_o for one cycle and loads chan_o with addr_i. chan_o changes at no other time.
- R2: Each falling edge counted inside the WIN_CYC-cycle window lowers the resolution by one bit. The conversion then lasts BASE_CYC >> k cycles, where k is the count, so each step halves the time.
- R3: Resolution starts at RES_MAX (16) and stops at RES_MIN (10). Window edges after the sixth give no acknowledge and change neither the conversion time nor the bit count.
- R4: SDAT is high after the start edge and after each counted window edge. It returns low on the next SCLK rise or at the end of the window, whichever is first.
- R5: During the conversion SDAT is low and falling SCLK edges are ignored. At completion SDAT goes high.
- R6: After completion, each falling edge drives the next result bit on SDAT, N = 16 - k bits in all. The bits are result_i[15] down to result_i[16-N], as sampled at completion.
- R7: If the N-bit result would be a 1 followed by N-1 zeros, its lowest bit is sent as 1 instead.
- R8: The falling edge after the N-th data bit starts a new conversion, so a full cycle takes 17 falling edges.
- R9: A SCLK pulse shorter than FILT_CYC system cycles produces no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from host, asynchronous |
| addr_i | input | CH_W | Channel address sampled at the start edge |
| result_i | input | RES_MAX | Two's-complement result from the converter model |
| sdat_o | output | 1 | Serial data, acknowledge and status line |
| chan_o | output | CH_W | Latched channel selection |
| start_o | output | 1 | One-cycle conversion start strobe |

## Verification
The assertions assume the host holds each SCLK level far longer than the filter length plus the two-flop delay. They also assume result_i is steady when the conversion completes. The stimulus holds every SCLK phase for 20 system cycles against a four-cycle filter. It changes result_i only between runs, while the block is reading out or asleep. The only intentionally short pulse is the two-cycle glitch aimed at the filter. Runs sweep the number of window edges from zero to eight, so they cover the resolution floor and a reserved pattern at three resolutions.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WIN,
    ST_CONV,
    ST_RDY,
    ST_READ
  } sdl_state_e;
endpackage

// File: rtl/sclk_cond.sv
module sclk_cond #(
  parameter int FILT_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  output logic fall_o,
  output logic rise_o
);
  localparam int CNT_W = $clog2(FILT_CYC + 1);

  logic s1_q, s2_q, filt_q;
  logic [CNT_W-1:0] cnt_q;
  logic upd;

  assign upd    = (s2_q != filt_q) && (cnt_q == CNT_W'(FILT_CYC - 1));
  assign fall_o = upd && !s2_q;
  assign rise_o = upd && s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      s1_q <= sclk_i;
      s2_q <= s1_q;
      if (s2_q == filt_q) begin
        cnt_q <= '0;
      end else if (upd) begin
        filt_q <= s2_q;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_FALL_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o); // R9
endmodule

// File: rtl/sdl_shreg.sv
module sdl_shreg #(
  parameter int DW    = 16,
  parameter int RED_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [RED_W-1:0] red_i,
  input  logic [DW-1:0]    data_i,
  output logic             bit_o
);
  localparam logic [DW-1:0] SIGN_ONLY = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0] sh_q;
  logic [DW-1:0] val;

  always_comb begin
    val = data_i & ({DW{1'b1}} << red_i);
    if (val == SIGN_ONLY) val = val | (DW'(1) << red_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      bit_o <= 1'b0;
    end else if (load_i) begin
      sh_q <= val;
    end else if (shift_i) begin
      bit_o <= sh_q[DW-1];
      sh_q  <= sh_q << 1;
    end
  end

  AST_NO_RESERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> sh_q != SIGN_ONLY); // R7
endmodule

// File: rtl/sdl_fsm.sv
module sdl_fsm
  import sdl_pkg::*;
#(
  parameter int CH_W     = 2,
  parameter int DW       = 16,
  parameter int MAX_RED  = 6,
  parameter int RED_W    = 3,
  parameter int WIN_CYC  = 4000,
  parameter int BASE_CYC = 65536
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_i,
  input  logic             rise_i,
  input  logic [CH_W-1:0]  addr_i,
  input  logic             bit_i,
  output logic             start_o,
  output logic [CH_W-1:0]  chan_o,
  output logic             load_o,
  output logic             shift_o,
  output logic [RED_W-1:0] red_o,
  output logic             sdat_o
);
  localparam int TMR_MAX = (WIN_CYC > BASE_CYC) ? WIN_CYC : BASE_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int LEFT_W  = $clog2(DW + 1);

  sdl_state_e        state_q;
  logic [TMR_W-1:0]  tmr_q;
  logic [LEFT_W-1:0] left_q;
  logic              ack_q;
  logic              go;

  // start from sleep, or once the last data bit is out
  assign go      = fall_i && (state_q == ST_IDLE ||
                              (state_q == ST_READ && left_q == '0));
  assign load_o  = (state_q == ST_CONV) && (tmr_q == '0);
  assign shift_o = fall_i && (state_q == ST_RDY ||
                              (state_q == ST_READ && left_q != '0));

  always_comb begin
    unique case (state_q)
      ST_WIN:  sdat_o = ack_q;
      ST_CONV: sdat_o = 1'b0;
      ST_READ: sdat_o = bit_i;
      default: sdat_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      left_q  <= '0;
      ack_q   <= 1'b0;
      red_o   <= '0;
      chan_o  <= '0;
      start_o <= 1'b0;
    end else begin
      start_o <= go;
      if (go) begin
        state_q <= ST_WIN;
        chan_o  <= addr_i;
        tmr_q   <= TMR_W'(WIN_CYC - 1);
        red_o   <= '0;
        ack_q   <= 1'b1;
      end else begin
        unique case (state_q)
          ST_WIN: begin
            if (tmr_q == '0) begin
              state_q <= ST_CONV;
              ack_q   <= 1'b0;
              tmr_q   <= TMR_W'(BASE_CYC >> red_o) - 1'b1;
            end else begin
              tmr_q <= tmr_q - 1'b1;
              if (fall_i && red_o != RED_W'(MAX_RED)) begin
                red_o <= red_o + 1'b1;
                ack_q <= 1'b1;
              end else if (rise_i) begin
                ack_q <= 1'b0;
              end
            end
          end
          ST_CONV: begin
            if (tmr_q == '0) state_q <= ST_RDY;
            else tmr_q <= tmr_q - 1'b1;
          end
          ST_RDY: begin
            if (fall_i) begin
              state_q <= ST_READ;
              left_q  <= LEFT_W'(DW - 1) - LEFT_W'(red_o);
            end
          end
          ST_READ: begin
            if (fall_i) left_q <= left_q - 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  AST_CHAN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(chan_o) |-> start_o); // R1
  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o); // R1
  AST_RED_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WIN && fall_i && red_o == RED_W'(MAX_RED)) |=> red_o == RED_W'(MAX_RED)); // R3
  AST_ACK_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WIN && rise_i && !fall_i) |=> !sdat_o); // R4
  AST_CONV_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV) |=> (state_q == ST_CONV || state_q == ST_RDY)); // R5
endmodule

// File: rtl/sdat_link.sv
module sdat_link #(
  parameter int CH_W     = 2,
  parameter int RES_MAX  = 16,
  parameter int RES_MIN  = 10,
  parameter int WIN_CYC  = 4000,
  parameter int BASE_CYC = 65536,
  parameter int FILT_CYC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic [CH_W-1:0]    addr_i,
  input  logic [RES_MAX-1:0] result_i,
  output logic               sdat_o,
  output logic [CH_W-1:0]    chan_o,
  output logic               start_o
);
  localparam int MAX_RED = RES_MAX - RES_MIN;
  localparam int RED_W   = $clog2(MAX_RED + 1);

  logic fall, rise, load, shift, dbit;
  logic [RED_W-1:0] red;

  sclk_cond #(.FILT_CYC(FILT_CYC)) u_cond (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i),
    .fall_o(fall), .rise_o(rise)
  );

  sdl_fsm #(
    .CH_W(CH_W), .DW(RES_MAX), .MAX_RED(MAX_RED), .RED_W(RED_W),
    .WIN_CYC(WIN_CYC), .BASE_CYC(BASE_CYC)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .fall_i(fall), .rise_i(rise),
    .addr_i(addr_i), .bit_i(dbit), .start_o(start_o), .chan_o(chan_o),
    .load_o(load), .shift_o(shift), .red_o(red), .sdat_o(sdat_o)
  );

  sdl_shreg #(.DW(RES_MAX), .RED_W(RED_W)) u_shreg (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .shift_i(shift),
    .red_i(red), .data_i(result_i), .bit_o(dbit)
  );
endmodule

// File: tb/sdat_link_tb.sv
`timescale 1ns/1ps
module sdat_link_tb;
  localparam int WIN  = 400;
  localparam int BASE = 2048;
  localparam int FILT = 4;
  localparam int HP   = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1;
  logic [1:0] addr = '0;
  logic [15:0] res = '0;
  logic sdat, start;
  logic [1:0] chan;

  int checks = 0, errors = 0, cyc = 0, starts = 0, t_start = 0;
  bit to = 1'b0;

  always #2.5 clk = ~clk;

  sdat_link #(.CH_W(2), .RES_MAX(16), .RES_MIN(10), .WIN_CYC(WIN),
              .BASE_CYC(BASE), .FILT_CYC(FILT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .addr_i(addr),
    .result_i(res), .sdat_o(sdat), .chan_o(chan), .start_o(start)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (start) starts <= starts + 1;
  end
  always @(negedge clk) if (start) t_start = cyc;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic phase(input logic lvl);
    sclk = lvl;
    repeat (HP - 1) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [15:0] pick(input int k);
    if (k == 0 || k == 3) return 16'h8000;
    if (k == 6) return 16'h8012;
    if (k == 8) return 16'h7FFF;
    return 16'((k + 1) * 16'h1234) ^ 16'hA5C3;
  endfunction

  initial begin
    int base_t, n0, re, nb, t_done, s0;
    logic [15:0] top;
    base_t = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(sdat === 1'b1, "R1 reset sdat", int'(sdat), 1);
    chk(start === 1'b0, "R1 reset start", int'(start), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // short low glitch
    sclk = 1'b0;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    repeat (20) @(negedge clk);
    chk(starts == 0, "R9 glitch start", starts, 0);
    chk(sdat === 1'b1, "R9 glitch sdat", int'(sdat), 1);

    for (int k = 0; k <= 8 && !to; k++) begin
      re = (k > 6) ? 6 : k;
      nb = 16 - re;
      addr = 2'(k);
      res = pick(k);
      s0 = starts;
      phase(1'b0);
      chk(starts == s0 + 1, (k == 0) ? "R1 start" : "R8 restart", starts, s0 + 1);
      chk(chan == 2'(k), "R1 chan", int'(chan), k);
      chk(sdat === 1'b1, "R4 start ack", int'(sdat), 1);
      phase(1'b1);
      chk(sdat === 1'b0, "R4 ack drop", int'(sdat), 0);
      for (int i = 0; i < k; i++) begin
        phase(1'b0);
        chk(sdat === (i < 6), (i < 6) ? "R4 reduce ack" : "R3 extra ignored",
            int'(sdat), int'(i < 6));
        phase(1'b1);
        chk(sdat === 1'b0, "R4 ack drop", int'(sdat), 0);
      end
      while (cyc - t_start < WIN + 10 && !to) @(negedge clk);
      chk(sdat === 1'b0, "R5 busy low", int'(sdat), 0);
      if (k == 0) begin
        sclk = 1'b0;
        repeat (10) @(negedge clk);
        sclk = 1'b1;
        repeat (10) @(negedge clk);
        chk(sdat === 1'b0, "R5 edge ignored", int'(sdat), 0);
        chk(starts == s0 + 1, "R5 no restart", starts, s0 + 1);
      end
      while (sdat !== 1'b1 && !to) @(negedge clk);
      t_done = cyc - t_start;
      if (k == 0) base_t = t_done;
      chk(t_done - base_t == (BASE >> re) - BASE,
          (k > 6) ? "R3 conv time" : "R2 conv time",
          t_done - base_t, (BASE >> re) - BASE);
      top = res >> re;
      if (top == (16'd1 << (nb - 1))) top = top | 16'd1;
      res = ~res; // changed after completion; must not affect readout
      for (int b = 0; b < nb; b++) begin
        phase(1'b0);
        chk(sdat === top[nb - 1 - b],
            (k == 0 || k == 3 || k == 6) ? "R7 data bit" : "R6 data bit",
            int'(sdat), int'(top[nb - 1 - b]));
        phase(1'b1);
      end
    end
    s0 = starts;
    phase(1'b0);
    chk(starts == s0 + 1, "R8 final restart", starts, s0 + 1);
    phase(1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    n0 = 0;
    wait (cyc > 150000);
    to = 1'b1;
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
  int n0;
endmodule